// File: doc/BRIEF.md
# Receiver Power Mode Arbiter

This block decides the power mode of a video and audio receiver. It has three modes: full power, auto power-down and power-down. The inputs are a software power-down bit, an auto power-down enable, a power-down pin whose polarity is programmable, and two activity flags from the clock and sync detectors. The outputs are enables for the PLL, core and output domains, and output enables for the pixel bus, the sync outputs, the S/PDIF pin and the I2S pins. Register bits arrive as plain inputs. The activity flags are synchronous to `clk`.

A power-down command always wins over the automatic decision. The command comes either from the software bit or from the pin. The pin has an option bit. With the bit clear, an asserted pin powers the receiver down. With the bit set, an asserted pin only releases the output pins to high impedance.

Loss of activity must last for a programmable number of clocks before the block drops into auto power-down. Return of activity brings the block back at the next edge. Each return to full power brings up the domains in order: PLL, then core, then outputs. Only the detection logic stays powered while the PLL, core and output domains are off.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held, `mode` is power-down (2'b10) and every domain enable and output enable is 0.
- R2: `sw_pd_n` at 0 selects power-down (`mode` = 2'b10) at the next clock edge, whatever the auto enable and activity inputs are.
- R3: With `sw_pd_n`=1, `auto_pd_en`=1 and both activity flags at 0, `mode` stays full power (2'b00) for `idle_limit` edges and becomes auto power-down (2'b01) at edge `idle_limit`+1.
- R4: In auto power-down, either activity flag at 1 returns `mode` to full power at the next edge.
- R5: With `auto_pd_en` at 0, the block never enters auto power-down.
- R6: In auto power-down and in power-down, `en_pll`, `en_core` and `en_out` are all 0.
- R7: On entering full power, `en_pll` rises in the first full-power cycle. `en_core` rises `CORE_DLY` cycles later and `en_out` rises `CORE_DLY`+`OUT_SETTLE` cycles later. Defaults are 4 and 8.
- R8: The pin is asserted when `pd_pin` equals `pd_pin_pol`. It passes through a two-flop synchronizer. With `pd_pin_hiz_only`=0, an asserted pin selects power-down three edges after it changes, and release does the same.
- R9: With `pd_pin_hiz_only`=1, an asserted pin clears all four output enables two edges after it changes. `mode` and the domain enables are unaffected.
- R10: Each of `hiz_pixel`, `hiz_sync`, `hiz_spdif` and `hiz_i2s` clears only its own output enable, in the same cycle.
- R11: When the command and the automatic condition are both present, power-down wins over auto power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_pd_n | input | 1 | Software power-down bit, 0 = power down |
| auto_pd_en | input | 1 | Enables auto power-down on inactivity |
| pd_pin | input | 1 | Asynchronous power-down pin |
| pd_pin_pol | input | 1 | Pin level that counts as asserted |
| pd_pin_hiz_only | input | 1 | 1 = asserted pin only three-states outputs |
| act_sync | input | 1 | Sync activity detected |
| act_clk | input | 1 | TMDS clock activity detected |
| idle_limit | input | IDLE_W | Inactive cycles tolerated before auto power-down |
| hiz_pixel | input | 1 | Force pixel data outputs to high impedance |
| hiz_sync | input | 1 | Force sync outputs to high impedance |
| hiz_spdif | input | 1 | Force S/PDIF output to high impedance |
| hiz_i2s | input | 1 | Force I2S outputs to high impedance |
| mode | output | 2 | 00 full power, 01 auto power-down, 10 power-down |
| en_pll | output | 1 | PLL domain enable |
| en_core | output | 1 | Core domain enable |
| en_out | output | 1 | Output domain enable |
| oe_pixel | output | 1 | Pixel data output enable |
| oe_sync | output | 1 | Sync output enable |
| oe_spdif | output | 1 | S/PDIF output enable |
| oe_i2s | output | 1 | I2S output enable |

## Verification
The assertions check on every cycle:
- the command forcing power-down;
- the domains being off outside full power;
- the domain enables staying nested PLL, core, outputs;
- activity and a cleared auto enable keeping the block out of auto power-down;
- each output enable following its own high-impedance bit.

The exact lengths of the timed windows can only be shown by the bench's scenarios. These are the debounce count against a randomly chosen `idle_limit`, the staged bring-up delays, and the pin synchronizer latency under both polarities. The bench's scenarios also show that the three-state-only pin option leaves the mode untouched.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int IDLE_W     = 12,
  parameter int CORE_DLY   = 4,
  parameter int OUT_SETTLE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_pd_n,
  input  logic              auto_pd_en,
  input  logic              pd_pin,
  input  logic              pd_pin_pol,
  input  logic              pd_pin_hiz_only,
  input  logic              act_sync,
  input  logic              act_clk,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              hiz_pixel,
  input  logic              hiz_sync,
  input  logic              hiz_spdif,
  input  logic              hiz_i2s,
  output logic [1:0]        mode,
  output logic              en_pll,
  output logic              en_core,
  output logic              en_out,
  output logic              oe_pixel,
  output logic              oe_sync,
  output logic              oe_spdif,
  output logic              oe_i2s
);
  localparam int OUT_DLY = CORE_DLY + OUT_SETTLE;
  localparam int SEQ_W   = $clog2(OUT_DLY + 1);
  localparam logic [1:0] M_FULL = 2'b00;
  localparam logic [1:0] M_AUTO = 2'b01;
  localparam logic [1:0] M_PD   = 2'b10;
  localparam logic [SEQ_W-1:0] CORE_AT = SEQ_W'(CORE_DLY);
  localparam logic [SEQ_W-1:0] OUT_AT  = SEQ_W'(OUT_DLY);

  logic [1:0]        pin_sync;
  logic [IDLE_W-1:0] idle_cnt;
  logic [SEQ_W-1:0]  seq_cnt;
  logic [1:0]        mode_q;
  logic              pin_on, cmd_pd, pin_hiz, active, auto_req, full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sync <= 2'b00;
    else        pin_sync <= {pin_sync[0], pd_pin};

  assign pin_on   = pd_pin_pol ? pin_sync[1] : ~pin_sync[1];
  assign cmd_pd   = ~sw_pd_n | (pin_on & ~pd_pin_hiz_only);
  assign pin_hiz  = pin_on & pd_pin_hiz_only;
  assign active   = act_sync | act_clk;
  assign auto_req = auto_pd_en & ~active & (idle_cnt >= idle_limit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      idle_cnt <= '0;
    else if (active || !auto_pd_en)  idle_cnt <= '0;
    else if (idle_cnt < idle_limit)  idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        mode_q <= M_PD;
    else if (cmd_pd)   mode_q <= M_PD;
    else if (auto_req) mode_q <= M_AUTO;
    else               mode_q <= M_FULL;

  assign full = (mode_q == M_FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                seq_cnt <= '0;
    else if (!full)            seq_cnt <= '0;
    else if (seq_cnt < OUT_AT) seq_cnt <= seq_cnt + 1'b1;

  assign mode     = mode_q;
  assign en_pll   = full;
  assign en_core  = full & (seq_cnt >= CORE_AT);
  assign en_out   = full & (seq_cnt >= OUT_AT);
  assign oe_pixel = en_out & ~pin_hiz & ~hiz_pixel;
  assign oe_sync  = en_out & ~pin_hiz & ~hiz_sync;
  assign oe_spdif = en_out & ~pin_hiz & ~hiz_spdif;
  assign oe_i2s   = en_out & ~pin_hiz & ~hiz_i2s;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_pd_n,
  input logic       auto_pd_en,
  input logic       act_sync,
  input logic       act_clk,
  input logic       hiz_pixel,
  input logic       hiz_sync,
  input logic       hiz_spdif,
  input logic       hiz_i2s,
  input logic [1:0] mode,
  input logic       en_pll,
  input logic       en_core,
  input logic       en_out,
  input logic       oe_pixel,
  input logic       oe_sync,
  input logic       oe_spdif,
  input logic       oe_i2s
);
  // R2
  sw_pd_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_pd_n |=> mode == 2'b10);
  // R6
  domains_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b00 |-> !en_pll && !en_core && !en_out);
  // R7
  seq_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_out |-> en_core) and (en_core |-> en_pll));
  // R7
  pll_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_pll) |-> !en_core);
  // R4
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && (act_sync || act_clk)) |=> mode != 2'b01);
  // R5
  auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_pd_en |=> mode != 2'b01);
  // R11
  cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_pd_n |=> mode != 2'b01);
  // R10
  oe_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_pixel |-> en_out && !hiz_pixel) and (oe_sync |-> en_out && !hiz_sync) and
    (oe_spdif |-> en_out && !hiz_spdif) and (oe_i2s |-> en_out && !hiz_i2s));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_pd_n(sw_pd_n), .auto_pd_en(auto_pd_en),
  .act_sync(act_sync), .act_clk(act_clk), .hiz_pixel(hiz_pixel),
  .hiz_sync(hiz_sync), .hiz_spdif(hiz_spdif), .hiz_i2s(hiz_i2s),
  .mode(mode), .en_pll(en_pll), .en_core(en_core), .en_out(en_out),
  .oe_pixel(oe_pixel), .oe_sync(oe_sync), .oe_spdif(oe_spdif), .oe_i2s(oe_i2s)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int IDLE_W = 12, CORE_DLY = 4, OUT_SETTLE = 8;
  localparam int OUT_DLY = CORE_DLY + OUT_SETTLE;

  logic clk = 0, rst_n = 0;
  logic sw_pd_n = 1, auto_pd_en = 0, pd_pin = 0, pd_pin_pol = 1, pd_pin_hiz_only = 0;
  logic act_sync = 1, act_clk = 1;
  logic [IDLE_W-1:0] idle_limit = 8;
  logic hiz_pixel = 0, hiz_sync = 0, hiz_spdif = 0, hiz_i2s = 0;
  logic [1:0] mode;
  logic en_pll, en_core, en_out, oe_pixel, oe_sync, oe_spdif, oe_i2s;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.IDLE_W(IDLE_W), .CORE_DLY(CORE_DLY), .OUT_SETTLE(OUT_SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_pd_n(sw_pd_n), .auto_pd_en(auto_pd_en),
    .pd_pin(pd_pin), .pd_pin_pol(pd_pin_pol), .pd_pin_hiz_only(pd_pin_hiz_only),
    .act_sync(act_sync), .act_clk(act_clk), .idle_limit(idle_limit),
    .hiz_pixel(hiz_pixel), .hiz_sync(hiz_sync), .hiz_spdif(hiz_spdif), .hiz_i2s(hiz_i2s),
    .mode(mode), .en_pll(en_pll), .en_core(en_core), .en_out(en_out),
    .oe_pixel(oe_pixel), .oe_sync(oe_sync), .oe_spdif(oe_spdif), .oe_i2s(oe_i2s));

  function automatic logic [3:0] exp_oe(logic out_on, logic pin_hiz, logic [3:0] mask);
    return (out_on && !pin_hiz) ? ~mask : 4'b0000;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int doms();
    return {en_pll, en_core, en_out};
  endfunction

  function automatic int oes();
    return {oe_pixel, oe_sync, oe_spdif, oe_i2s};
  endfunction

  task automatic to_full();
    sw_pd_n = 1; auto_pd_en = 0; act_sync = 1; act_clk = 1;
    pd_pin = ~pd_pin_pol; pd_pin_hiz_only = 0;
    step(OUT_DLY + 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    check("R1 mode", mode, 2);
    check("R1 domains", doms(), 0);
    check("R1 oe", oes(), 0);
    rst_n = 1;
    step(1);
    check("R7 first full cycle mode", mode, 0);
    check("R7 pll only", doms(), 3'b100);
    step(CORE_DLY - 1);
    check("R7 core not yet", doms(), 3'b100);
    step(1);
    check("R7 core up", doms(), 3'b110);
    step(OUT_SETTLE - 1);
    check("R7 out not yet", doms(), 3'b110);
    step(1);
    check("R7 out up", doms(), 3'b111);
    check("R10 all oe", oes(), 4'hF);

    // R2 / R11: command wins over auto with no activity
    auto_pd_en = 1; act_sync = 0; act_clk = 0; idle_limit = 0; sw_pd_n = 0;
    step(1);
    check("R2 sw power-down", mode, 2);
    check("R6 pd domains off", doms(), 0);
    step(5);
    check("R11 cmd beats auto", mode, 2);
    to_full();

    // R3 / R4 / R6 randomized debounce windows
    for (int i = 0; i < 12; i++) begin
      int lim;
      lim = 1 + int'($urandom_range(40));
      idle_limit = IDLE_W'(lim);
      auto_pd_en = 1; act_sync = 0; act_clk = 0;
      step(lim);
      check("R3 still full at limit", mode, 0);
      step(1);
      check("R3 auto entered", mode, 1);
      check("R6 auto domains off", doms(), 0);
      if (i % 2 == 0) act_clk = 1; else act_sync = 1;
      step(1);
      check("R4 wake", mode, 0);
      check("R7 wake pll", doms(), 3'b100);
      step(OUT_DLY + 2);
    end

    // R5
    auto_pd_en = 0; act_sync = 0; act_clk = 0; idle_limit = 3;
    step(20);
    check("R5 no auto when disabled", mode, 0);
    to_full();

    // R8 both polarities
    for (int p = 0; p < 2; p++) begin
      pd_pin_pol = p[0]; pd_pin = ~pd_pin_pol;
      to_full();
      pd_pin = pd_pin_pol;
      step(2);
      check("R8 pin sync latency", mode, 0);
      step(1);
      check("R8 pin power-down", mode, 2);
      pd_pin = ~pd_pin_pol;
      step(2);
      check("R8 pin held", mode, 2);
      step(1);
      check("R8 pin release", mode, 0);
    end
    to_full();

    // R9
    pd_pin_hiz_only = 1; pd_pin = pd_pin_pol;
    step(1);
    check("R9 oe before sync", oes(), 4'hF);
    step(1);
    check("R9 oe released", oes(), int'(exp_oe(1'b1, 1'b1, 4'h0)));
    check("R9 mode kept", mode, 0);
    check("R9 domains kept", doms(), 3'b111);
    pd_pin = ~pd_pin_pol;
    step(2);
    check("R9 oe back", oes(), 4'hF);

    // R10 random masks
    for (int k = 0; k < 16; k++) begin
      logic [3:0] m;
      m = (k < 4) ? 4'(1 << k) : 4'($urandom_range(15));
      {hiz_pixel, hiz_sync, hiz_spdif, hiz_i2s} = m;
      step(1);
      check("R10 hiz mask", oes(), int'(exp_oe(1'b1, 1'b0, m)));
    end
    {hiz_pixel, hiz_sync, hiz_spdif, hiz_i2s} = 4'h0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule